// File: doc/BRIEF.md
# Dual-Mode Digital Phase Comparator

This block measures the phase relationship between a reference square wave and a feedback square wave, both asynchronous to a fast system clock. Each input is brought into the system-clock domain through a two-stage synchroniser, and rising edges are detected on the synchronised levels. A selectable comparison stage then forms a phase-error pulse stream. In level mode the error is high whenever the two synchronised inputs disagree. In edge mode a reference rising edge sets the error and a feedback rising edge clears it, so each error pulse lasts as long as the feedback edge lags the reference edge.

An averaging stage counts the system clocks in which the error is high, over a fixed window of `WIN_LEN` clocks. At the end of each window it converts that count into an unsigned code scaled to the width `CODE_W` and raises a one-clock valid strobe. If the two inputs share a frequency, the code is a steady phase estimate. If they do not, successive codes wander at the difference frequency. Changing the mode discards the partial window and the edge-mode state, so the first result after a switch covers only the new mode.

Top module: `dual_mode_phase_cmp`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `phase_code` is 0, `code_valid` is 0 and `err_pulse` is 0.
- R2: With `mode_sel`=0 (level mode), `err_pulse` equals the XOR of the two inputs after each has passed two synchroniser flops, registered once more: a change on an input reaches `err_pulse` three clocks later.
- R3: With `mode_sel`=1 (edge mode), a rising edge of the synchronised reference sets `err_pulse` and a rising edge of the synchronised feedback clears it. When both edges occur in the same cycle, the error goes low. With no edge, the error holds its value.
- R4: `code_valid` is high for exactly one clock at the end of each window, and in steady operation consecutive strobes are exactly `WIN_LEN` clocks apart.
- R5: The code equals floor(H * 2^CODE_W / WIN_LEN), where H is the number of error-high clocks in the window. It saturates at 2^CODE_W - 1 when that quotient would not fit. `phase_code` holds its value between strobes.
- R6: In level mode, with equal periods and 50% duty on both inputs, the code rises linearly from 0 at zero offset to full scale (saturated) at half-period offset, and falls symmetrically beyond it.
- R7: The level-mode result depends on input duty cycle. The edge-mode result depends only on the edge offset, and equals the lag in clocks times 2^CODE_W/WIN_LEN per period in the window.
- R8: A change of `mode_sel` clears `err_pulse` on the next clock and restarts the window. The next strobe appears `WIN_LEN`+1 clocks after the new value is first sampled.
- R9: When the two input frequencies differ, successive codes do not settle to a single value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback square wave, asynchronous |
| mode_sel | input | 1 | 0 = level (XOR) comparison, 1 = edge (set/clear) comparison |
| err_pulse | output | 1 | Registered phase-error pulse stream |
| phase_code | output | CODE_W | Scaled error-high count of the last window |
| code_valid | output | 1 | One-clock strobe when `phase_code` updates |

## Verification
The bench sweeps every integer clock offset across a full period in both modes. This exposes a swapped set/clear priority: edge mode would report full scale instead of zero when the edges coincide. The sweep also exposes an XOR stage that was really an AND, because its code would fold the wrong way past the half-period point. The half-period level-mode case drives the count to exactly the window length. A scaler without saturation would wrap it to zero. Narrow-duty inputs separate the two modes, and a mismatched feedback period shows the code beating. Mode switches made mid-window and mid-pulse would reveal a stale pulse or a window that was not restarted, because the next strobe would arrive early.

// File: rtl/phcmp_pkg.sv
package phcmp_pkg;

    typedef enum logic {
        CMP_LEVEL = 1'b0,
        CMP_EDGE  = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/phcmp_sync.sv
module phcmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.chain[STAGES-1];
    assign rise  = st_q.chain[STAGES-1] & ~st_q.last;
endmodule

// File: rtl/phcmp_pulse.sv
module phcmp_pulse
    import phcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_sel,
    input  logic ref_lvl,
    input  logic fb_lvl,
    input  logic ref_rise,
    input  logic fb_rise,
    output logic err,
    output logic restart
);
    typedef struct packed {
        cmp_mode_e mode;
        logic      err;
    } pulse_state_t;

    pulse_state_t st_d, st_q;
    cmp_mode_e    mode_req;

    assign mode_req = cmp_mode_e'(mode_sel);
    assign restart  = (mode_req != st_q.mode);

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_req;
        if (restart) begin
            st_d.err = 1'b0;
        end else begin
            unique case (st_q.mode)
                CMP_LEVEL: st_d.err = ref_lvl ^ fb_lvl;
                CMP_EDGE: begin
                    if (fb_rise)       st_d.err = 1'b0;
                    else if (ref_rise) st_d.err = 1'b1;
                end
                default: st_d.err = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: CMP_LEVEL, err: 1'b0};
        else        st_q <= st_d;
    end

    assign err = st_q.err;
endmodule

// File: rtl/phcmp_avg.sv
module phcmp_avg #(
    parameter int CODE_W  = 8,
    parameter int WIN_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err,
    input  logic              restart,
    output logic [CODE_W-1:0] code,
    output logic              valid
);
    localparam int CNT_W  = $clog2(WIN_LEN + 1);
    localparam int IDX_W  = $clog2(WIN_LEN);
    localparam int PROD_W = CNT_W + CODE_W;
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WIN_LEN - 1);
    localparam logic [PROD_W-1:0] WIN_DIV  = PROD_W'(WIN_LEN);
    localparam logic [PROD_W-1:0] CODE_MAX = PROD_W'((1 << CODE_W) - 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  acc;
        logic [CODE_W-1:0] code;
        logic              valid;
    } avg_state_t;

    avg_state_t        st_d, st_q;
    logic [CNT_W-1:0]  hi_total;
    logic [PROD_W-1:0] scaled;

    assign hi_total = st_q.acc + CNT_W'(err);
    assign scaled   = {hi_total, {CODE_W{1'b0}}} / WIN_DIV;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (restart) begin
            st_d.idx = '0;
            st_d.acc = '0;
        end else if (st_q.idx == LAST_IDX) begin
            st_d.code  = (scaled > CODE_MAX) ? CODE_MAX[CODE_W-1:0] : scaled[CODE_W-1:0];
            st_d.valid = 1'b1;
            st_d.idx   = '0;
            st_d.acc   = '0;
        end else begin
            st_d.idx = st_q.idx + 1'b1;
            st_d.acc = hi_total;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code  = st_q.code;
    assign valid = st_q.valid;
endmodule

// File: rtl/dual_mode_phase_cmp.sv
module dual_mode_phase_cmp #(
    parameter int CODE_W      = 8,
    parameter int WIN_LEN     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              fb_in,
    input  logic              mode_sel,
    output logic              err_pulse,
    output logic [CODE_W-1:0] phase_code,
    output logic              code_valid
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] rise;
    logic ref_lvl, fb_lvl, ref_rise, fb_rise, restart;

    assign raw_in = {fb_in, ref_in};

    for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
        phcmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[i]),
            .level    (lvl[i]),
            .rise     (rise[i])
        );
    end

    assign ref_lvl  = lvl[0];
    assign fb_lvl   = lvl[1];
    assign ref_rise = rise[0];
    assign fb_rise  = rise[1];

    phcmp_pulse u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .ref_lvl  (ref_lvl),
        .fb_lvl   (fb_lvl),
        .ref_rise (ref_rise),
        .fb_rise  (fb_rise),
        .err      (err_pulse),
        .restart  (restart)
    );

    phcmp_avg #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN)) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .err     (err_pulse),
        .restart (restart),
        .code    (phase_code),
        .valid   (code_valid)
    );
endmodule

// File: rtl/phcmp_checker.sv
module phcmp_checker #(
    parameter int CODE_W  = 8,
    parameter int WIN_LEN = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_sel,
    input logic              ref_lvl,
    input logic              fb_lvl,
    input logic              ref_rise,
    input logic              fb_rise,
    input logic              restart,
    input logic              err_pulse,
    input logic [CODE_W-1:0] phase_code,
    input logic              code_valid
);
    localparam int GAP_W = $clog2(WIN_LEN + 2);

    logic [1:0]       age_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
            gap_q <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            if (restart || code_valid) gap_q <= '0;
            else if (gap_q <= GAP_W'(WIN_LEN)) gap_q <= gap_q + 1'b1;
        end
    end

    // level mode: error follows the synchronised XOR one clock later
    assert_level_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(mode_sel) == 1'b0 && !$past(restart))
            |-> (err_pulse == $past(ref_lvl ^ fb_lvl)));

    // edge mode: lone reference edge sets, feedback edge clears
    assert_edge_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !restart && ref_rise && !fb_rise) |=> err_pulse);

    assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !restart && fb_rise) |=> !err_pulse);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |=> !code_valid);

    assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_W'(WIN_LEN));

    assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && !code_valid) |-> $stable(phase_code));

    assert_switch_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !err_pulse);
endmodule

bind dual_mode_phase_cmp phcmp_checker #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .ref_lvl    (ref_lvl),
    .fb_lvl     (fb_lvl),
    .ref_rise   (ref_rise),
    .fb_rise    (fb_rise),
    .restart    (restart),
    .err_pulse  (err_pulse),
    .phase_code (phase_code),
    .code_valid (code_valid)
);

// File: tb/dual_mode_phase_cmp_test.sv
`timescale 1ns/1ps
module dual_mode_phase_cmp_test;
    localparam int CODE_W  = 6;
    localparam int WIN_LEN = 64;
    localparam int MAXC    = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic mode_sel = 1'b0;
    logic err_pulse;
    logic [CODE_W-1:0] phase_code;
    logic code_valid;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int t = 0;
    int per_r = 16, per_f = 16, duty_r = 8, duty_f = 8, off = 0;

    always #2.5 clk = ~clk;

    dual_mode_phase_cmp #(.CODE_W(CODE_W), .WIN_LEN(WIN_LEN)) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .mode_sel(mode_sel), .err_pulse(err_pulse),
        .phase_code(phase_code), .code_valid(code_valid)
    );

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        t++;
        ref_in = ((t % per_r) < duty_r);
        fb_in  = (((t + 1000 * per_f - off) % per_f) < duty_f);
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!code_valid && n < 4 * WIN_LEN);
    endtask

    task automatic measure(output int code);
        int n;
        for (int k = 0; k < 3; k++) wait_valid(n);
        code = phase_code;
    endtask

    function automatic int tri_dist(input int d);
        return (d < 8) ? d : 16 - d;
    endfunction

    initial begin
        int c, e, n;
        int seen [6];
        bit varied;

        // R1 reset state
        repeat (4) tick();
        check(phase_code == 0 && !code_valid && !err_pulse, "R1 reset", phase_code, 0);
        rst_n = 1'b1;
        tick();
        check(phase_code == 0 && !code_valid && !err_pulse, "R1 after release", phase_code, 0);

        // R2 R6 R5: level mode sweep, 50% duty
        mode_sel = 1'b0;
        tick();
        for (int d = 0; d < 16; d++) begin
            off = d;
            measure(c);
            e = 8 * tri_dist(d);
            if (e > MAXC) e = MAXC;
            check(c == e, $sformatf("R2/R6/R5 level offset %0d", d), c, e);
        end

        // R4 strobe spacing
        wait_valid(n);
        wait_valid(n);
        check(n == WIN_LEN, "R4 strobe spacing", n, WIN_LEN);
        tick();
        check(!code_valid, "R4 strobe width", code_valid, 0);

        // R3 R7: edge mode sweep
        mode_sel = 1'b1;
        tick();
        for (int d = 0; d < 16; d++) begin
            off = d;
            measure(c);
            e = 4 * d;
            check(c == e, $sformatf("R3/R7 edge offset %0d", d), c, e);
        end

        // R7 narrow duty: edge mode unaffected
        duty_r = 4; duty_f = 4;
        for (int d = 2; d < 16; d += 5) begin
            off = d;
            measure(c);
            e = 4 * d;
            check(c == e, $sformatf("R7 edge duty4 offset %0d", d), c, e);
        end

        // R7 narrow duty: level mode changes
        mode_sel = 1'b0;
        off = 8;
        measure(c);
        check(c == 32, "R7 level duty4 offset 8", c, 32);
        off = 2;
        measure(c);
        check(c == 16, "R7 level duty4 offset 2", c, 16);

        // R8 switch mid-pulse clears error and restarts the window
        duty_r = 8; duty_f = 8; off = 10;
        mode_sel = 1'b1;
        measure(c);
        wait_valid(n);
        repeat (10) tick();
        n = 0;
        while (!err_pulse && n < 32) begin tick(); n++; end
        mode_sel = 1'b0;
        tick();
        check(!err_pulse, "R8 error cleared on switch", err_pulse, 0);
        n = 1;
        while (!code_valid && n < 4 * WIN_LEN) begin tick(); n++; end
        check(n == WIN_LEN + 1, "R8 window restart", n, WIN_LEN + 1);

        // R9 unequal frequencies beat
        per_f = 17; off = 0;
        measure(c);
        varied = 0;
        for (int k = 0; k < 6; k++) begin
            wait_valid(n);
            seen[k] = phase_code;
            if (k > 0 && seen[k] != seen[0]) varied = 1;
        end
        check(varied, "R9 beating codes", seen[5], -1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule